// File: doc/BRIEF.md
# Flag-Setting Data-Processing ALU

This block is the integer execute stage of a load-store RISC core. Each cycle it takes a 4-bit operation code, a first operand and a second operand that has already passed through the barrel shifter, together with the shifter's carry-out and a marker saying whether a shift actually happened. From these it computes a 32-bit result and a register-write enable in the same cycle, without any clocked stage.

The block holds the N, Z, C and V condition flags in a small register of its own. The current flag values feed the carry-chained operations, and the next flag values are stored on the clock edge of an issued operation. What gets updated depends on the operation class. Arithmetic updates all four flags. Logical and move operations update N and Z, keep V, and take C from the shifter only when a shift took place. The four compare/test operations always update the flags and never write a register. Every other operation touches the flags only when the instruction asks for it.

The carry-propagate adder can be built as one wide addition or as an explicit ripple chain, selected by a parameter. The flags' reset value is also a parameter.

Top module: `dpalu_top`

## Requirements
- R1: Operation codes are AND=0, EOR=1, SUB=2, RSB=3, ADD=4, ADC=5, SBC=6, RSC=7, TST=8, TEQ=9, CMP=10, CMN=11, ORR=12, MOV=13, BIC=14, MVN=15. AND, EOR and ORR give the bitwise and, xor and or of the operands, and BIC gives opa AND NOT opb.
- R2: ADD gives opa+opb, ADC gives opa+opb+C, SUB gives opa-opb, and SBC gives opa-opb+C-1, all modulo 2^32.
- R3: RSB gives opb-opa and RSC gives opb-opa+C-1, modulo 2^32.
- R4: MOV returns opb and MVN returns the bitwise complement of opb.
- R5: TST (and), TEQ (xor), CMP (opa-opb) and CMN (opa+opb) never raise wr_en, and they always update the flags when issued, whatever set_flags is.
- R6: Any other operation raises wr_en when issued. It updates the flags only when set_flags is high. With set_flags low, the flags keep their value.
- R7: Arithmetic operations (SUB, RSB, ADD, ADC, SBC, RSC, CMP, CMN) load all four flags. C is the carry out of the addition, which for subtraction is NOT borrow (1 when no borrow occurs). V is set on signed two's-complement overflow.
- R8: Logical and move operations (AND, EOR, TST, TEQ, ORR, MOV, BIC, MVN) keep V. They load C from shift_cout when shift_used is high, and keep C otherwise.
- R9: On a flag update, N is bit 31 of the result and Z is 1 exactly when the 32-bit result is zero. The nzcv output packs the flags as {N,Z,C,V}, with N in bit 3.
- R10: After reset nzcv is 0000. When issue is low the flags do not change and wr_en is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| issue | input | 1 | An operation is presented this cycle |
| op | input | 4 | Operation code |
| opa | input | 32 | First operand |
| opb | input | 32 | Shifted second operand |
| shift_cout | input | 1 | Carry-out of the shifter |
| shift_used | input | 1 | A shift took place on opb |
| set_flags | input | 1 | Instruction requests a flag update |
| result | output | 32 | Operation result |
| wr_en | output | 1 | Write the result to the destination register |
| nzcv | output | 4 | Current flags {N,Z,C,V} |

## Verification
The logical codes are driven with complementary and overlapping bit patterns, so that AND, OR, XOR and bit-clear give visibly different words. Arithmetic is run at the signed and unsigned wrap points: 0x7FFFFFFF+1, 0xFFFFFFFF+1, 0-1, 0x80000000-1 and equal operands. These inputs separate carry from overflow and borrow from no-borrow. The carry-chained and reverse forms are run with the held carry both set and clear, which shows whether the flag is actually consumed. Flag gating is exercised by repeating one operation with set_flags low and then high, with shift_used both set and clear, and with issue idle.

// File: rtl/dpalu_pkg.sv
package dpalu_pkg;

   typedef enum logic [3:0] {
      OP_AND = 4'd0,  OP_EOR = 4'd1,  OP_SUB = 4'd2,  OP_RSB = 4'd3,
      OP_ADD = 4'd4,  OP_ADC = 4'd5,  OP_SBC = 4'd6,  OP_RSC = 4'd7,
      OP_TST = 4'd8,  OP_TEQ = 4'd9,  OP_CMP = 4'd10, OP_CMN = 4'd11,
      OP_ORR = 4'd12, OP_MOV = 4'd13, OP_BIC = 4'd14, OP_MVN = 4'd15
   } dp_op_e;

   typedef struct packed {
      logic n;
      logic z;
      logic c;
      logic v;
   } nzcv_t;

   // compare/test class: flags only, no register write
   function automatic logic is_test(input logic [3:0] o);
      return (o[3:2] == 2'b10);
   endfunction

   // logical and move class: V kept, C from shifter
   function automatic logic is_logic(input logic [3:0] o);
      case (o)
         OP_AND, OP_EOR, OP_TST, OP_TEQ,
         OP_ORR, OP_MOV, OP_BIC, OP_MVN: return 1'b1;
         default:                        return 1'b0;
      endcase
   endfunction

endpackage

// File: rtl/dpalu_adder.sv
module dpalu_adder #(
   parameter int WIDTH = 32,
   parameter int STYLE = 0        // 0: single wide add, 1: explicit ripple chain
) (
   input  logic [WIDTH-1:0] x,
   input  logic [WIDTH-1:0] y,
   input  logic             cin,
   output logic [WIDTH-1:0] sum,
   output logic             cout,
   output logic             ovf
);
   localparam int MSB = WIDTH - 1;

   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("dpalu_adder: WIDTH must be at least 2");
      end
      if (STYLE != 0 && STYLE != 1) begin : g_bad_style
         $error("dpalu_adder: STYLE must be 0 or 1");
      end

      if (STYLE == 0) begin : g_wide
         logic [WIDTH:0] full;
         assign full = {1'b0, x} + {1'b0, y} + {{WIDTH{1'b0}}, cin};
         assign sum  = full[MSB:0];
         assign cout = full[WIDTH];
      end else begin : g_ripple
         logic [WIDTH:0] cy;
         assign cy[0] = cin;
         for (genvar i = 0; i < WIDTH; i++) begin : g_bit
            assign sum[i]  = x[i] ^ y[i] ^ cy[i];
            assign cy[i+1] = (x[i] & y[i]) | (cy[i] & (x[i] ^ y[i]));
         end
         assign cout = cy[WIDTH];
      end
   endgenerate

   // signed overflow: like-signed inputs produce an opposite-signed sum
   assign ovf = (x[MSB] == y[MSB]) && (sum[MSB] != x[MSB]);

endmodule

// File: rtl/dpalu_logic.sv
module dpalu_logic
   import dpalu_pkg::*;
#(
   parameter int WIDTH = 32
) (
   input  logic [3:0]       op,
   input  logic [WIDTH-1:0] x,
   input  logic [WIDTH-1:0] y,
   output logic [WIDTH-1:0] res
);
   always_comb begin
      case (op)
         OP_AND, OP_TST: res = x & y;
         OP_EOR, OP_TEQ: res = x ^ y;
         OP_ORR:         res = x | y;
         OP_BIC:         res = x & ~y;
         OP_MOV:         res = y;
         OP_MVN:         res = ~y;
         default:        res = '0;
      endcase
   end

endmodule

// File: rtl/dpalu_flags.sv
module dpalu_flags
   import dpalu_pkg::*;
#(
   parameter logic [3:0] RESET_VAL = 4'b0000
) (
   input  logic  clk,
   input  logic  rst_n,
   input  logic  we,
   input  nzcv_t nxt,
   output nzcv_t cur
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  cur <= nzcv_t'(RESET_VAL);
      else if (we) cur <= nxt;
   end

   AST_FLAGS_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !we |=> $stable(cur)); // R10

endmodule

// File: rtl/dpalu_top.sv
module dpalu_top
   import dpalu_pkg::*;
#(
   parameter int         WIDTH       = 32,
   parameter int         ADDER_STYLE = 0,
   parameter logic [3:0] FLAG_RESET  = 4'b0000
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             issue,
   input  logic [3:0]       op,
   input  logic [WIDTH-1:0] opa,
   input  logic [WIDTH-1:0] opb,
   input  logic             shift_cout,
   input  logic             shift_used,
   input  logic             set_flags,
   output logic [WIDTH-1:0] result,
   output logic             wr_en,
   output logic [3:0]       nzcv
);
   localparam int MSB = WIDTH - 1;

   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("dpalu_top: WIDTH must be at least 2");
      end
   endgenerate

   nzcv_t            cur_f, nxt_f;
   logic [WIDTH-1:0] add_x, add_y, add_sum, log_res;
   logic             add_cin, add_cout, add_ovf, reverse, negate_b;
   logic             arith, logical, flag_we;

   // operand steering for the shared adder
   always_comb begin
      reverse  = (op == OP_RSB) || (op == OP_RSC);
      negate_b = (op == OP_SUB) || (op == OP_SBC) || (op == OP_CMP);
      add_x    = reverse ? opb : opa;
      add_y    = reverse ? ~opa : (negate_b ? ~opb : opb);
      case (op)
         OP_SUB, OP_RSB, OP_CMP: add_cin = 1'b1;
         OP_ADC, OP_SBC, OP_RSC: add_cin = cur_f.c;
         default:                add_cin = 1'b0;
      endcase
   end

   dpalu_adder #(.WIDTH(WIDTH), .STYLE(ADDER_STYLE)) u_add (
      .x(add_x), .y(add_y), .cin(add_cin),
      .sum(add_sum), .cout(add_cout), .ovf(add_ovf)
   );

   dpalu_logic #(.WIDTH(WIDTH)) u_log (
      .op(op), .x(opa), .y(opb), .res(log_res)
   );

   assign logical = is_logic(op);
   assign arith   = !logical;
   assign result  = logical ? log_res : add_sum;
   assign wr_en   = issue && !is_test(op);
   assign flag_we = issue && (set_flags || is_test(op));

   always_comb begin
      nxt_f.n = result[MSB];
      nxt_f.z = (result == '0);
      nxt_f.c = arith ? add_cout : (shift_used ? shift_cout : cur_f.c);
      nxt_f.v = arith ? add_ovf  : cur_f.v;
   end

   dpalu_flags #(.RESET_VAL(FLAG_RESET)) u_flags (
      .clk(clk), .rst_n(rst_n), .we(flag_we), .nxt(nxt_f), .cur(cur_f)
   );

   assign nzcv = cur_f;

   AST_TEST_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (op[3:2] == 2'b10) |-> !wr_en); // R5
   AST_NOSET_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      (issue && !set_flags && op[3:2] != 2'b10) |=> $stable(nzcv)); // R6
   AST_LOGIC_V_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      (issue && logical) |=> (nzcv[0] == $past(nzcv[0]))); // R8
   AST_LOGIC_C_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      (issue && logical && !shift_used) |=> (nzcv[1] == $past(nzcv[1]))); // R8
   AST_Z_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
      (issue && (set_flags || op[3:2] == 2'b10)) |=> (nzcv[2] == ($past(result) == '0))); // R9
   AST_N_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
      (issue && (set_flags || op[3:2] == 2'b10)) |=> (nzcv[3] == $past(result[MSB]))); // R9
   AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      !issue |-> !wr_en); // R10

endmodule

// File: tb/tb_dpalu_top.sv
module tb_dpalu_top;
   localparam int CLK_P = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        issue = 1'b0;
   logic [3:0]  op = '0;
   logic [31:0] opa = '0, opb = '0;
   logic        shift_cout = 1'b0, shift_used = 1'b0, set_flags = 1'b0;
   logic [31:0] result;
   logic        wr_en;
   logic [3:0]  nzcv;

   int checks = 0;
   int fails  = 0;
   logic [3:0] exp_f = 4'b0000;   // bench model of {N,Z,C,V}

   always #(CLK_P/2) clk = ~clk;

   dpalu_top dut (
      .clk(clk), .rst_n(rst_n), .issue(issue), .op(op), .opa(opa), .opb(opb),
      .shift_cout(shift_cout), .shift_used(shift_used), .set_flags(set_flags),
      .result(result), .wr_en(wr_en), .nzcv(nzcv)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // reference: expected result, write enable and flags from the requirements
   task automatic run_op(input string req, input logic [3:0] o, input logic [31:0] a,
                         input logic [31:0] b, input logic sf, input logic su, input logic sc);
      logic [31:0] r;
      logic        is_ar, wr, upd, c, v;
      longint      ua, ub, sa, sb, cin, u, s;
      ua = longint'(a); ub = longint'(b);
      sa = longint'($signed(a)); sb = longint'($signed(b));
      cin = longint'(exp_f[1]);
      is_ar = 1'b1; u = 0; s = 0;
      case (o)
         4'd0, 4'd8:  begin r = a & b;  is_ar = 0; end
         4'd1, 4'd9:  begin r = a ^ b;  is_ar = 0; end
         4'd12:       begin r = a | b;  is_ar = 0; end
         4'd14:       begin r = a & ~b; is_ar = 0; end
         4'd13:       begin r = b;      is_ar = 0; end
         4'd15:       begin r = ~b;     is_ar = 0; end
         4'd2, 4'd10: begin u = ua - ub;           s = sa - sb;           end
         4'd3:        begin u = ub - ua;           s = sb - sa;           end
         4'd4, 4'd11: begin u = ua + ub;           s = sa + sb;           end
         4'd5:        begin u = ua + ub + cin;     s = sa + sb + cin;     end
         4'd6:        begin u = ua - ub + cin - 1; s = sa - sb + cin - 1; end
         default:     begin u = ub - ua + cin - 1; s = sb - sa + cin - 1; end
      endcase
      if (is_ar) begin
         r = u[31:0];
         if (o == 4'd4 || o == 4'd5 || o == 4'd11) c = (u > 64'sd4294967295);
         else                                       c = (u >= 0);
         v = (s > 64'sd2147483647) || (s < -64'sd2147483648);
      end else begin
         c = su ? sc : exp_f[1];
         v = exp_f[0];
      end
      wr  = (o[3:2] != 2'b10);
      upd = sf || !wr;
      @(negedge clk);
      op = o; opa = a; opb = b; set_flags = sf; shift_used = su; shift_cout = sc;
      issue = 1'b1;
      #1;
      chk({req, " result"}, result, r);
      chk("R5/R6 wr_en", {31'b0, wr_en}, {31'b0, wr});
      if (upd) exp_f = {r[31], (r == 32'd0), c, v};
      @(posedge clk); #1;
      issue = 1'b0;
      chk({req, " flags"}, {28'b0, nzcv}, {28'b0, exp_f});
   endtask

   task automatic t_reset();
      chk("R10 reset flags", {28'b0, nzcv}, 32'd0);
      chk("R10 reset wr_en", {31'b0, wr_en}, 32'd0);
   endtask

   task automatic t_logic();
      run_op("R1 AND", 4'd0,  32'hF0F0_FF00, 32'hFF00_F0F0, 1, 0, 0);
      run_op("R1 EOR", 4'd1,  32'hF0F0_FF00, 32'hFF00_F0F0, 1, 0, 0);
      run_op("R1 ORR", 4'd12, 32'hF0F0_FF00, 32'hFF00_F0F0, 1, 0, 0);
      run_op("R1 BIC", 4'd14, 32'hF0F0_FF00, 32'hFF00_F0F0, 1, 0, 0);
   endtask

   task automatic t_move();
      run_op("R4 MOV", 4'd13, 32'h1234_5678, 32'h8000_0001, 1, 0, 0);
      run_op("R4 MVN", 4'd15, 32'h1234_5678, 32'hFFFF_FFFF, 1, 0, 0);
   endtask

   task automatic t_arith();
      run_op("R7 ADD signed overflow", 4'd4, 32'h7FFF_FFFF, 32'h1, 1, 0, 0);
      run_op("R7 ADD carry to zero",   4'd4, 32'hFFFF_FFFF, 32'h1, 1, 0, 0);
      run_op("R2 ADC carry in set",    4'd5, 32'h10, 32'h20, 1, 0, 0);
      run_op("R7 SUB borrow",          4'd2, 32'h0, 32'h1, 1, 0, 0);
      run_op("R2 SBC carry clear",     4'd6, 32'h100, 32'h10, 1, 0, 0);
      run_op("R7 SUB equal",           4'd2, 32'h55, 32'h55, 1, 0, 0);
      run_op("R2 SBC carry set",       4'd6, 32'h100, 32'h10, 1, 0, 0);
      run_op("R7 SUB signed overflow", 4'd2, 32'h8000_0000, 32'h1, 1, 0, 0);
   endtask

   task automatic t_reverse();
      run_op("R3 RSB", 4'd3, 32'h5, 32'h3, 1, 0, 0);
      run_op("R3 RSC carry clear", 4'd7, 32'h5, 32'h9, 1, 0, 0);
      run_op("R3 RSC carry set",   4'd7, 32'h5, 32'h9, 1, 0, 0);
   endtask

   task automatic t_compare();
      run_op("R5 CMP", 4'd10, 32'h3, 32'h7, 0, 0, 0);
      run_op("R5 CMN", 4'd11, 32'hFFFF_FFFF, 32'h1, 0, 0, 0);
      run_op("R5 TST", 4'd8,  32'hF0, 32'h0F, 0, 1, 1);
      run_op("R5 TEQ", 4'd9,  32'h8000_0000, 32'h0, 0, 0, 0);
   endtask

   task automatic t_gate();
      run_op("R6 ADD no set", 4'd4, 32'h0, 32'h0, 0, 0, 0);
      run_op("R6 SUB no set", 4'd2, 32'h0, 32'h1, 0, 0, 0);
      run_op("R8 AND shift carry", 4'd0, 32'h0, 32'h0, 1, 1, 1);
      run_op("R8 MOV keep carry",  4'd13, 32'h0, 32'h4, 1, 0, 0);
      run_op("R8 EOR shift carry clear", 4'd1, 32'h1, 32'h1, 1, 1, 0);
      run_op("R9 MOV negative", 4'd13, 32'h0, 32'hC000_0000, 1, 0, 0);
   endtask

   task automatic t_idle();
      @(negedge clk);
      op = 4'd4; opa = 32'h1; opb = 32'h1; set_flags = 1'b1; issue = 1'b0;
      #1;
      chk("R10 idle wr_en", {31'b0, wr_en}, 32'd0);
      @(posedge clk); #1;
      chk("R10 idle flags", {28'b0, nzcv}, {28'b0, exp_f});
   endtask

   initial begin
      #(CLK_P * 2000);
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      #(CLK_P * 2 + 2);
      t_reset();
      rst_n = 1'b1;
      t_logic();
      t_move();
      t_arith();
      t_reverse();
      t_compare();
      t_gate();
      t_idle();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule